// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block turns 32-bit virtual addresses into physical addresses for 4 KB pages. It keeps a small set of recent page mappings and compares the page number of every request against all of them in parallel. A request that matches returns the physical address, the page's write permission and its dirty state in the same cycle. A request that matches nothing raises `miss`.

On a miss, a page-table walker outside the block fetches the page-table entry and offers it on the refill port for one cycle. If the entry is present, the block stores it on the next clock edge and the requester retries. If the entry is marked not present, the block raises `page_fault` and stores nothing. Each entry has a reference bit. When every slot is occupied, a rotating pointer picks the slot to replace: it passes over slots whose reference bit is set and clears those bits on the way. A flush input drops every mapping in one cycle, for example on a context switch.

Top module: `tlb_xlate`

## Requirements
- R1: While `lookup_valid` is low, `hit`, `miss` and `prot_fault` are all low. After reset every slot is empty, so any lookup misses.
- R2: A lookup is resolved in the same cycle. At most one of `hit`, `miss` and `prot_fault` is high. `miss` is high when no occupied slot holds VPN = `lookup_va[31:12]`.
- R3: On `hit`, `pa` equals the stored 20-bit PPN in bits 31:12 and `lookup_va[11:0]` in bits 11:0. `hit_rw` and `hit_dirty` show that entry's write permission (1 = read-write) and dirty bit.
- R4: A write lookup (`lookup_we` = 1) that matches a read-only entry raises `prot_fault` instead of `hit`, and does not change the entry's dirty bit.
- R5: A write hit sets the entry's dirty bit. A later hit on that entry shows `hit_dirty` = 1. A read hit leaves the dirty bit unchanged.
- R6: A refill with `refill_present` = 1 is stored on the clock edge that samples it. A lookup in that same cycle still misses, and lookups from the next cycle on hit. A newly stored entry has its reference bit set and takes its dirty bit from `refill_dirty`.
- R7: A refill with `refill_present` = 0 raises `page_fault` in the same cycle and stores nothing.
- R8: A refill goes into the lowest-numbered empty slot while one exists. Filling empty slots does not move the replacement pointer.
- R9: With every slot occupied, the refill replaces the first slot at or after the pointer, wrapping round, whose reference bit is clear. It clears the reference bits of the slots it passes, then moves the pointer one past the replaced slot. If every reference bit is set, all are cleared and the slot under the pointer is replaced. A hit that is not a protection fault sets the entry's reference bit.
- R10: `flush` empties every slot on the next edge. A refill in the same cycle as a flush is not stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all slots |
| lookup_valid | input | 1 | Translation request |
| lookup_we | input | 1 | Request is a write |
| lookup_va | input | 32 | Virtual address |
| hit | output | 1 | Translation valid |
| miss | output | 1 | No mapping held |
| prot_fault | output | 1 | Write to read-only page |
| pa | output | 32 | Physical address, meaningful on hit |
| hit_rw | output | 1 | Matched entry is read-write |
| hit_dirty | output | 1 | Matched entry is dirty |
| refill_valid | input | 1 | Refill strobe from the walker |
| refill_present | input | 1 | Fetched entry's valid bit |
| refill_vpn | input | 20 | VPN of the fetched entry |
| refill_ppn | input | 20 | PPN of the fetched entry |
| refill_rw | input | 1 | Fetched entry is read-write |
| refill_dirty | input | 1 | Fetched entry's dirty bit |
| page_fault | output | 1 | Fetched entry not present |

## Verification
The random part draws read and write lookups from a pool of 14 page numbers with random offsets. Because the pool is larger than the eight slots, the stream covers hits, misses, protection faults, page faults, evictions and occasional flushes. Every miss is followed by a refill, and a reference model predicts which page each replacement removes, so a wrong victim later shows up as an unexpected hit or miss. Directed sequences cover the remaining cases:
- a full sweep in which every reference bit is set;
- a pointer that skips one recently hit slot;
- a lookup in the same cycle as its own refill;
- a refill in the same cycle as a flush;
- a write to a read-only page followed by a read of that page, which shows whether the dirty bit changed.

// File: rtl/tlb_xlate.sv
`timescale 1ns/1ps
module tlb_xlate #(
  parameter int VA_W    = 32,
  parameter int OFF_W   = 12,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   flush,
  input  logic                   lookup_valid,
  input  logic                   lookup_we,
  input  logic [VA_W-1:0]        lookup_va,
  output logic                   hit,
  output logic                   miss,
  output logic                   prot_fault,
  output logic [PPN_W+OFF_W-1:0] pa,
  output logic                   hit_rw,
  output logic                   hit_dirty,
  input  logic                   refill_valid,
  input  logic                   refill_present,
  input  logic [VA_W-OFF_W-1:0]  refill_vpn,
  input  logic [PPN_W-1:0]       refill_ppn,
  input  logic                   refill_rw,
  input  logic                   refill_dirty,
  output logic                   page_fault
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int IW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld, refb, dirt, wr;
  logic [ENTRIES-1:0] vld_n, refb_n, dirt_n;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IW-1:0]      hand, hand_n;

  logic [VPN_W-1:0]   req_vpn;
  logic [ENTRIES-1:0] match;
  logic [IW-1:0]      sel;
  logic               any_match, ro_write;

  assign req_vpn = lookup_va[VA_W-1:OFF_W];

  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      match[i] = vld[i] && (tag_q[i] == req_vpn);
      if (match[i]) sel = IW'(i);
    end
  end

  assign any_match  = |match;
  assign ro_write   = lookup_we && !wr[sel];
  assign hit        = lookup_valid && any_match && !ro_write;
  assign prot_fault = lookup_valid && any_match && ro_write;
  assign miss       = lookup_valid && !any_match;
  assign pa         = {ppn_q[sel], lookup_va[OFF_W-1:0]};
  assign hit_rw     = wr[sel];
  assign hit_dirty  = dirt[sel];
  assign page_fault = refill_valid && !refill_present;

  logic               do_fill, free_any;
  logic [IW-1:0]      free_idx, sweep_idx, victim, probe;
  logic [ENTRIES-1:0] sweep_clr;
  logic               sweep_found;

  assign do_fill = refill_valid && refill_present && !flush;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!vld[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  always_comb begin
    sweep_found = 1'b0;
    sweep_idx   = hand;
    sweep_clr   = '0;
    probe       = hand;
    for (int k = 0; k < ENTRIES; k++) begin
      probe = hand + IW'(k);
      if (!sweep_found) begin
        if (!refb[probe]) begin
          sweep_found = 1'b1;
          sweep_idx   = probe;
        end else begin
          sweep_clr[probe] = 1'b1;
        end
      end
    end
  end

  assign victim = free_any ? free_idx : sweep_idx;

  always_comb begin
    vld_n  = vld;
    refb_n = refb;
    dirt_n = dirt;
    hand_n = hand;
    if (do_fill && !free_any) begin
      refb_n = refb_n & ~sweep_clr;
      hand_n = victim + IW'(1);
    end
    if (hit) begin
      refb_n[sel] = 1'b1;
      if (lookup_we) dirt_n[sel] = 1'b1;
    end
    if (do_fill) begin
      vld_n[victim]  = 1'b1;
      refb_n[victim] = 1'b1;
      dirt_n[victim] = refill_dirty;
    end
    if (flush) vld_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= '0;
      refb <= '0;
      dirt <= '0;
      wr   <= '0;
      hand <= '0;
    end else begin
      vld  <= vld_n;
      refb <= refb_n;
      dirt <= dirt_n;
      hand <= hand_n;
      if (do_fill) begin
        wr[victim]    <= refill_rw;
        tag_q[victim] <= refill_vpn;
        ppn_q[victim] <= refill_ppn;
      end
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
`timescale 1ns/1ps
module tlb_xlate_chk #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  lookup_valid,
  input logic                  lookup_we,
  input logic [VA_W-1:0]       lookup_va,
  input logic                  hit,
  input logic                  miss,
  input logic                  prot_fault,
  input logic                  hit_dirty,
  input logic                  refill_valid,
  input logic                  refill_present,
  input logic [VA_W-OFF_W-1:0] refill_vpn
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |-> !(hit || miss || prot_fault));

  a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss, prot_fault}));

  a_r6_refill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid && refill_present && !flush) |=>
      ((lookup_valid && lookup_va[VA_W-1:OFF_W] == $past(refill_vpn)) -> !miss));

  a_r5_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && lookup_we && !flush && !refill_valid) |=>
      ((hit && $stable(lookup_va)) -> hit_dirty));

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !(hit || prot_fault));
endmodule

bind tlb_xlate tlb_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lookup_valid(lookup_valid),
  .lookup_we(lookup_we), .lookup_va(lookup_va), .hit(hit), .miss(miss),
  .prot_fault(prot_fault), .hit_dirty(hit_dirty), .refill_valid(refill_valid),
  .refill_present(refill_present), .refill_vpn(refill_vpn)
);

// File: tb/tb_tlb_xlate.sv
`timescale 1ns/1ps
module tb_tlb_xlate;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic lookup_valid = 1'b0, lookup_we = 1'b0;
  logic [31:0] lookup_va = '0;
  logic hit, miss, prot_fault, hit_rw, hit_dirty, page_fault;
  logic [31:0] pa;
  logic refill_valid = 1'b0, refill_present = 1'b0, refill_rw = 1'b0, refill_dirty = 1'b0;
  logic [19:0] refill_vpn = '0, refill_ppn = '0;

  always #2.5 clk = ~clk;

  tlb_xlate dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lookup_valid(lookup_valid),
    .lookup_we(lookup_we), .lookup_va(lookup_va), .hit(hit), .miss(miss),
    .prot_fault(prot_fault), .pa(pa), .hit_rw(hit_rw), .hit_dirty(hit_dirty),
    .refill_valid(refill_valid), .refill_present(refill_present),
    .refill_vpn(refill_vpn), .refill_ppn(refill_ppn), .refill_rw(refill_rw),
    .refill_dirty(refill_dirty), .page_fault(page_fault)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  bit          mv [8];
  bit          mrw[8], md[8], mr[8];
  logic [19:0] mvpn[8], mppn[8];
  int          mhand = 0;

  function automatic int m_find(logic [19:0] vpn);
    for (int i = 0; i < 8; i++) if (mv[i] && mvpn[i] == vpn) return i;
    return -1;
  endfunction

  function automatic void m_install(logic [19:0] vpn, logic [19:0] ppn, bit rw, bit dy);
    int v = -1;
    for (int i = 0; i < 8; i++) if (v < 0 && !mv[i]) v = i;
    if (v < 0) begin
      for (int k = 0; k < 8; k++) begin
        int p = (mhand + k) % 8;
        if (v < 0) begin
          if (!mr[p]) v = p; else mr[p] = 1'b0;
        end
      end
      if (v < 0) v = mhand;
      mhand = (v + 1) % 8;
    end
    mv[v] = 1'b1; mvpn[v] = vpn; mppn[v] = ppn; mrw[v] = rw; md[v] = dy; mr[v] = 1'b1;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic idle_inputs();
    lookup_valid = 1'b0; lookup_we = 1'b0; refill_valid = 1'b0;
    refill_present = 1'b0; flush = 1'b0;
  endtask

  task automatic do_lookup(logic [19:0] vpn, logic [11:0] off, bit we, string tag);
    int idx;
    bit eh, ep, em;
    @(negedge clk);
    idle_inputs();
    lookup_valid = 1'b1; lookup_we = we; lookup_va = {vpn, off};
    #1;
    idx = m_find(vpn);
    em = (idx < 0);
    ep = !em && we && !mrw[idx];
    eh = !em && !ep;
    chk(tag, "hit", {31'd0, hit}, {31'd0, eh});
    chk(tag, "miss", {31'd0, miss}, {31'd0, em});
    chk(tag, "prot_fault", {31'd0, prot_fault}, {31'd0, ep});
    if (eh) begin
      chk(tag, "pa", pa, {mppn[idx], off});
      chk(tag, "hit_rw", {31'd0, hit_rw}, {31'd0, mrw[idx]});
      chk(tag, "hit_dirty", {31'd0, hit_dirty}, {31'd0, md[idx]});
    end
    if (ep) chk(tag, "dirty kept", {31'd0, hit_dirty}, {31'd0, md[idx]});
    @(posedge clk);
    if (eh) begin
      mr[idx] = 1'b1;
      if (we) md[idx] = 1'b1;
    end
  endtask

  task automatic do_refill(logic [19:0] vpn, logic [19:0] ppn, bit pres, bit rw, bit dy, string tag);
    @(negedge clk);
    idle_inputs();
    refill_valid = 1'b1; refill_present = pres; refill_vpn = vpn;
    refill_ppn = ppn; refill_rw = rw; refill_dirty = dy;
    #1;
    chk(tag, "page_fault", {31'd0, page_fault}, {31'd0, !pres});
    @(posedge clk);
    if (pres) m_install(vpn, ppn, rw, dy);
  endtask

  task automatic do_flush();
    @(negedge clk);
    idle_inputs();
    flush = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 8; i++) mv[i] = 1'b0;
  endtask

  function automatic logic [19:0] pool(int k);
    return 20'(k * 20'h1F3 + 20'h40);
  endfunction

  initial begin
    #750000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 8; i++) begin mv[i] = 0; mr[i] = 0; md[i] = 0; mrw[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    #1;
    chk("R1", "idle hit", {31'd0, hit}, 32'd0);
    chk("R1", "idle miss", {31'd0, miss}, 32'd0);
    do_lookup(20'h12345, 12'h678, 1'b0, "R1 reset empty");

    @(negedge clk);
    idle_inputs();
    lookup_valid = 1'b1; lookup_va = {20'hABCDE, 12'h111};
    refill_valid = 1'b1; refill_present = 1'b1; refill_vpn = 20'hABCDE;
    refill_ppn = 20'h0F0F0; refill_rw = 1'b1; refill_dirty = 1'b0;
    #1;
    chk("R6", "same-cycle miss", {31'd0, miss}, 32'd1);
    @(posedge clk);
    m_install(20'hABCDE, 20'h0F0F0, 1'b1, 1'b0);
    do_lookup(20'hABCDE, 12'hFFF, 1'b0, "R6 R3 refill visible");

    do_refill(20'h00777, 20'h11111, 1'b0, 1'b1, 1'b0, "R7 fault");
    do_lookup(20'h00777, 12'h000, 1'b0, "R7 not stored");

    do_refill(20'h00500, 20'h22222, 1'b1, 1'b0, 1'b0, "R4 ro fill");
    do_lookup(20'h00500, 12'h004, 1'b1, "R4 ro write");
    do_lookup(20'h00500, 12'h008, 1'b0, "R4 dirty unchanged");
    do_lookup(20'hABCDE, 12'h010, 1'b0, "R5 read keeps clean");
    do_lookup(20'hABCDE, 12'h020, 1'b1, "R5 write hit");
    do_lookup(20'hABCDE, 12'h030, 1'b0, "R5 dirty seen");

    @(negedge clk);
    idle_inputs();
    flush = 1'b1; refill_valid = 1'b1; refill_present = 1'b1;
    refill_vpn = 20'h0BEEF; refill_ppn = 20'h33333; refill_rw = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 8; i++) mv[i] = 1'b0;
    do_lookup(20'h0BEEF, 12'h0, 1'b0, "R10 flush beats refill");
    do_lookup(20'hABCDE, 12'h0, 1'b0, "R10 flushed");

    for (int k = 0; k < 8; k++) do_refill(20'hA0000 + 20'(k), 20'h50000 + 20'(k), 1'b1, 1'b1, 1'b0, "R8 fill");
    do_refill(20'hA0008, 20'h50008, 1'b1, 1'b1, 1'b0, "R9 all ref set");
    do_lookup(20'hA0000, 12'h0, 1'b0, "R9 slot0 replaced");
    do_lookup(20'hA0002, 12'h0, 1'b0, "R9 mark ref");
    do_refill(20'hA0009, 20'h50009, 1'b1, 1'b1, 1'b0, "R9 next");
    do_refill(20'hA000A, 20'h5000A, 1'b1, 1'b1, 1'b0, "R9 skip");
    do_lookup(20'hA0001, 12'h0, 1'b0, "R9 slot1 replaced");
    do_lookup(20'hA0003, 12'h0, 1'b0, "R9 referenced slot skipped");
    do_lookup(20'hA0002, 12'h0, 1'b0, "R9 kept");
    do_lookup(20'hA000A, 12'h0, 1'b0, "R9 new entry");

    do_flush();
    for (int n = 0; n < 1500; n++) begin
      logic [19:0] v;
      bit we;
      v  = pool(int'($urandom % 14));
      we = $urandom % 3 == 0;
      if ($urandom % 60 == 0) do_flush();
      do_lookup(v, 12'($urandom), we, "R2 R3 random");
      if (m_find(v) < 0)
        do_refill(v, 20'($urandom), ($urandom % 8) != 0, $urandom % 2 == 0, $urandom % 4 == 0, "R6 R7 R9 random");
    end

    @(negedge clk);
    idle_inputs();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule